// File: doc/BRIEF.md
# Dependent Add Pair Fusion Unit

This execution unit takes two consecutive integer add operations in a single issue slot and finishes both in one clock. The first operation forms a scaled-index address style sum, `base + (index << scale)`. The second operation adds a displacement to one register source.

When the second operation reads the register the first one writes, it does not wait for that result. The unit instead computes `base + (index << scale) + displacement` with a three-input adder in the same cycle. This borrows the first operation's operands, which costs one source read beyond a lone add. When the second operation reads some other register, each add runs on its own two-input path.

Both results leave through two registered writeback channels. The intermediate write is dropped when the second operation overwrites the same destination. A scheduler places this unit where it would otherwise issue two serially dependent adds across two cycles.

Top module: `addpair_fuse_unit`

## Requirements
- R1: One cycle after an accepted valid first op, writeback channel 0 carries `op0_base + (op0_index << op0_scale)`.
- R2: The 2-bit scale field selects a multiplier on the index of 1, 2, 4 or 8 for codes 0, 1, 2 and 3.
- R3: When both ops are valid and `op1_src` equals `op0_dst`, channel 1 carries `op0_base + (op0_index << op0_scale) + op1_disp`, and `op1_src_val` has no effect.
- R4: When `op1_src` differs from `op0_dst`, or op0 is invalid, channel 1 carries `op1_src_val + op1_disp`.
- R5: When both ops are valid with different destinations, both writeback valids are high in the same cycle.
- R6: When both ops are valid and share a destination, channel 0 writes nothing and channel 1 writes the final value.
- R7: An invalid op0 produces no channel 0 writeback and never triggers fusion, even when its tag matches `op1_src`.
- R8: An invalid op1 produces no channel 1 writeback, and channel 0 behaves as in R1.
- R9: A low `rst_n` sampled at a rising edge clears both writeback valids at that edge.
- R10: All sums wrap modulo 2^DATA_W, and index bits shifted past the top are lost.
- R11: Each writeback tag equals the destination tag of the op it belongs to.
- R12: Writebacks appear exactly one cycle after their inputs, and an idle cycle produces no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op0_vld | input | 1 | First op present |
| op0_dst | input | TAG_W | First op destination tag |
| op0_base | input | DATA_W | First op base value |
| op0_index | input | DATA_W | First op index value |
| op0_scale | input | 2 | First op index shift, 0 to 3 |
| op1_vld | input | 1 | Second op present |
| op1_dst | input | TAG_W | Second op destination tag |
| op1_src | input | TAG_W | Second op register source tag |
| op1_src_val | input | DATA_W | Second op register source value (ignored on fusion) |
| op1_disp | input | DATA_W | Second op displacement |
| wb0_vld | output | 1 | Channel 0 write request |
| wb0_tag | output | TAG_W | Channel 0 destination tag |
| wb0_data | output | DATA_W | Channel 0 result |
| wb1_vld | output | 1 | Channel 1 write request |
| wb1_tag | output | TAG_W | Channel 1 destination tag |
| wb1_data | output | DATA_W | Channel 1 result |

## Verification
The assertions check on every cycle that a fused result on channel 1 equals the channel 0 sum plus the displacement. They also check that the two channels never write the same tag together, that a write request only follows a valid op, and that tags follow their op and reset clears both valids. The bench scenarios alone show the absolute arithmetic: each scale code, wrap-around, the independent path, the ignored source value on fusion, and an invalid first op whose tag matches the second op's source.

// File: rtl/addpair_pkg.sv
// Shared definitions for the dependent add pair fusion unit.
// Assumes: scale is a 2-bit shift count (x1, x2, x4, x8).
package addpair_pkg;
    localparam int SCALE_W = 2;

    // Which datapath feeds the second op's result
    typedef enum logic {
        ROUTE_SPLIT = 1'b0,
        ROUTE_FUSED = 1'b1
    } op1_route_e;
endpackage

// File: rtl/addpair_adder.sv
// Shifted adder: base + (index << scale), optionally + disp.
// Assumes: all arithmetic wraps at W bits; THREE selects the three-input form.
module addpair_adder #(
    parameter int W       = 64,
    parameter int SH_W    = 2,
    parameter bit THREE   = 1'b0
) (
    input  logic [W-1:0]    base,
    input  logic [W-1:0]    index,
    input  logic [SH_W-1:0] scale,
    input  logic [W-1:0]    disp,
    output logic [W-1:0]    sum
);
    logic [W-1:0] scaled;

    // Short left shift of the index operand
    always_comb scaled = index << scale;

    generate
        if (THREE) begin : g_three
            // Three-operand sum for the collapsed dependent pair
            always_comb sum = base + scaled + disp;
        end else begin : g_two
            logic unused_disp;
            always_comb unused_disp = ^disp;
            // Two-operand sum; displacement not used in this variant
            always_comb sum = base + scaled;
        end
    endgenerate
endmodule

// File: rtl/addpair_dep_detect.sv
// Dependency detection and writeback suppression for the op pair.
// Assumes: op1 follows op0 in program order, so op1 wins on a shared destination.
module addpair_dep_detect
    import addpair_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             op0_vld,
    input  logic             op1_vld,
    input  logic [TAG_W-1:0] op0_dst,
    input  logic [TAG_W-1:0] op1_src,
    input  logic [TAG_W-1:0] op1_dst,
    output op1_route_e       route,
    output logic             wr0,
    output logic             wr1
);
    logic both;

    // Both slots hold a real op
    always_comb both = op0_vld && op1_vld;

    // Fuse only when op1 reads what a valid op0 writes
    always_comb route = (both && (op1_src == op0_dst)) ? ROUTE_FUSED : ROUTE_SPLIT;

    // Drop op0's write when op1 overwrites the same register
    always_comb wr0 = op0_vld && !(both && (op1_dst == op0_dst));

    // op1 writes whenever it is present
    always_comb wr1 = op1_vld;
endmodule

// File: rtl/addpair_wb_stage.sv
// One registered writeback channel: valid, tag and data.
// Assumes: synchronous active-low reset; tag and data load every cycle.
module addpair_wb_stage #(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [TAG_W-1:0]  tag,
    input  logic [DATA_W-1:0] data,
    output logic              vld_q,
    output logic [TAG_W-1:0]  tag_q,
    output logic [DATA_W-1:0] data_q
);
    // Capture the writeback request at the clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            tag_q  <= '0;
            data_q <= '0;
        end else begin
            vld_q  <= wr;
            tag_q  <= tag;
            data_q <= data;
        end
    end

    // R9: the cycle reset is released, no write request is pending
    assert_reset_clear_R9: assert property (@(posedge clk) $rose(rst_n) |-> !vld_q);

    // R12: a write request only follows a request one cycle earlier
    assert_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> $past(wr));
endmodule

// File: rtl/addpair_fuse_unit.sv
// Dependent add pair fusion unit: executes two adds in one cycle, collapsing
// a dependent pair into one three-input shifted add.
// Assumes: operand values arrive already read from the register file.
module addpair_fuse_unit
    import addpair_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op0_vld,
    input  logic [TAG_W-1:0]   op0_dst,
    input  logic [DATA_W-1:0]  op0_base,
    input  logic [DATA_W-1:0]  op0_index,
    input  logic [SCALE_W-1:0] op0_scale,
    input  logic               op1_vld,
    input  logic [TAG_W-1:0]   op1_dst,
    input  logic [TAG_W-1:0]   op1_src,
    input  logic [DATA_W-1:0]  op1_src_val,
    input  logic [DATA_W-1:0]  op1_disp,
    output logic               wb0_vld,
    output logic [TAG_W-1:0]   wb0_tag,
    output logic [DATA_W-1:0]  wb0_data,
    output logic               wb1_vld,
    output logic [TAG_W-1:0]   wb1_tag,
    output logic [DATA_W-1:0]  wb1_data
);
    localparam logic [SCALE_W-1:0] NO_SHIFT = '0;

    op1_route_e        route;
    logic              wr0, wr1;
    logic [DATA_W-1:0] sum0, sum_fused, sum_split, res1;

    addpair_dep_detect #(.TAG_W(TAG_W)) dep_i (
        .op0_vld (op0_vld),
        .op1_vld (op1_vld),
        .op0_dst (op0_dst),
        .op1_src (op1_src),
        .op1_dst (op1_dst),
        .route   (route),
        .wr0     (wr0),
        .wr1     (wr1)
    );

    // op0: base + scaled index
    addpair_adder #(.W(DATA_W), .SH_W(SCALE_W), .THREE(1'b0)) add0_i (
        .base  (op0_base),
        .index (op0_index),
        .scale (op0_scale),
        .disp  (op1_disp),
        .sum   (sum0)
    );

    // op1 fused: op0 operands plus displacement, same cycle
    addpair_adder #(.W(DATA_W), .SH_W(SCALE_W), .THREE(1'b1)) add_fused_i (
        .base  (op0_base),
        .index (op0_index),
        .scale (op0_scale),
        .disp  (op1_disp),
        .sum   (sum_fused)
    );

    // op1 independent: register source plus displacement
    addpair_adder #(.W(DATA_W), .SH_W(SCALE_W), .THREE(1'b0)) add_split_i (
        .base  (op1_src_val),
        .index (op1_disp),
        .scale (NO_SHIFT),
        .disp  (op1_disp),
        .sum   (sum_split)
    );

    // Pick op1's result path from the dependency decision
    always_comb res1 = (route == ROUTE_FUSED) ? sum_fused : sum_split;

    addpair_wb_stage #(.TAG_W(TAG_W), .DATA_W(DATA_W)) wb0_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr0),
        .tag    (op0_dst),
        .data   (sum0),
        .vld_q  (wb0_vld),
        .tag_q  (wb0_tag),
        .data_q (wb0_data)
    );

    addpair_wb_stage #(.TAG_W(TAG_W), .DATA_W(DATA_W)) wb1_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr1),
        .tag    (op1_dst),
        .data   (res1),
        .vld_q  (wb1_vld),
        .tag_q  (wb1_tag),
        .data_q (wb1_data)
    );

    // R3: a fused result equals channel 0's sum plus the displacement
    assert_fused_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(route == ROUTE_FUSED) |-> (wb1_data == wb0_data + $past(op1_disp)));

    // R6: both channels never write the same register together
    assert_no_dup_dst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb0_vld && wb1_vld) |-> (wb0_tag != wb1_tag));

    // R7: channel 0 writes only after a valid op0
    assert_wb0_needs_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb0_vld |-> $past(op0_vld));

    // R8: channel 1 writes only after a valid op1
    assert_wb1_needs_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb1_vld |-> $past(op1_vld));

    // R11: each tag follows its own op's destination
    assert_tags_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wb1_vld |-> wb1_tag == $past(op1_dst)) and (wb0_vld |-> wb0_tag == $past(op0_dst)));
endmodule

// File: tb/addpair_fuse_unit_tb.sv
module addpair_fuse_unit_tb_top;
    localparam int DW = 64;
    localparam int TW = 6;

    typedef struct packed {
        logic          v0;
        logic [TW-1:0] d0;
        logic [DW-1:0] a0;
        logic [DW-1:0] b0;
        logic [1:0]    s0;
        logic          v1;
        logic [TW-1:0] d1;
        logic [TW-1:0] src;
        logic [DW-1:0] x1;
        logic [DW-1:0] i1;
        logic          e0v;
        logic [DW-1:0] e0;
        logic          e1v;
        logic [DW-1:0] e1;
    } vec_t;

    // Hand-computed vectors (see comments for requirement coverage)
    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        // R1 R4 R5: independent pair, 10+3=13, 100+7=107
        '{1'b1, 6'd1, 64'd10, 64'd3, 2'd0, 1'b1, 6'd2, 6'd5, 64'd100, 64'd7, 1'b1, 64'd13, 1'b1, 64'd107},
        // R2 R8: scale x2, 100+10=110, op1 invalid
        '{1'b1, 6'd3, 64'd100, 64'd5, 2'd1, 1'b0, 6'd4, 6'd3, 64'd1, 64'd1, 1'b1, 64'd110, 1'b0, 64'd0},
        // R2 R3: scale x4, 1+24=25, fused 25+4=29, src value 999 ignored
        '{1'b1, 6'd3, 64'd1, 64'd6, 2'd2, 1'b1, 6'd7, 6'd3, 64'd999, 64'd4, 1'b1, 64'd25, 1'b1, 64'd29},
        // R2 R6: scale x8, 0+16, fused same dest 16+5=21, wb0 dropped
        '{1'b1, 6'd8, 64'd0, 64'd2, 2'd3, 1'b1, 6'd8, 6'd8, 64'd50, 64'd5, 1'b0, 64'd0, 1'b1, 64'd21},
        // R6: independent same dest, 40+2=42, wb0 dropped
        '{1'b1, 6'd9, 64'd1, 64'd1, 2'd0, 1'b1, 6'd9, 6'd12, 64'd40, 64'd2, 1'b0, 64'd0, 1'b1, 64'd42},
        // R7: op0 invalid with tag matching op1 src, op1 uses 70+3=73
        '{1'b0, 6'd10, 64'd5, 64'd5, 2'd0, 1'b1, 6'd11, 6'd10, 64'd70, 64'd3, 1'b0, 64'd0, 1'b1, 64'd73},
        // R12: idle cycle, no writes
        '{1'b0, 6'd0, 64'd0, 64'd0, 2'd0, 1'b0, 6'd0, 6'd0, 64'd0, 64'd0, 1'b0, 64'd0, 1'b0, 64'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op0_vld = 1'b0, op1_vld = 1'b0;
    logic [TW-1:0] op0_dst = '0, op1_dst = '0, op1_src = '0;
    logic [DW-1:0] op0_base = '0, op0_index = '0, op1_src_val = '0, op1_disp = '0;
    logic [1:0]    op0_scale = '0;
    logic          wb0_vld, wb1_vld;
    logic [TW-1:0] wb0_tag, wb1_tag;
    logic [DW-1:0] wb0_data, wb1_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    addpair_fuse_unit #(.DATA_W(DW), .TAG_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .op0_vld(op0_vld), .op0_dst(op0_dst), .op0_base(op0_base),
        .op0_index(op0_index), .op0_scale(op0_scale),
        .op1_vld(op1_vld), .op1_dst(op1_dst), .op1_src(op1_src),
        .op1_src_val(op1_src_val), .op1_disp(op1_disp),
        .wb0_vld(wb0_vld), .wb0_tag(wb0_tag), .wb0_data(wb0_data),
        .wb1_vld(wb1_vld), .wb1_tag(wb1_tag), .wb1_data(wb1_data)
    );

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op0_vld = v.v0; op0_dst = v.d0; op0_base = v.a0; op0_index = v.b0;
        op0_scale = v.s0; op1_vld = v.v1; op1_dst = v.d1; op1_src = v.src;
        op1_src_val = v.x1; op1_disp = v.i1;
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge
    task automatic run_vec(input string req, input vec_t v);
        @(negedge clk);
        drive(v);
        @(negedge clk);
        check(req, "wb0_vld", {63'd0, wb0_vld}, {63'd0, v.e0v});
        check(req, "wb1_vld", {63'd0, wb1_vld}, {63'd0, v.e1v});
        if (v.e0v) begin
            check(req, "wb0_data", wb0_data, v.e0);
            check("R11", "wb0_tag", {58'd0, wb0_tag}, {58'd0, v.d0});
        end
        if (v.e1v) begin
            check(req, "wb1_data", wb1_data, v.e1);
            check("R11", "wb1_tag", {58'd0, wb1_tag}, {58'd0, v.d1});
        end
    endtask

    initial begin
        vec_t w;
        // R9: reset held with valid inputs pending
        w = VEC[0];
        drive(w);
        repeat (3) @(negedge clk);
        check("R9", "wb0_vld in reset", {63'd0, wb0_vld}, 64'd0);
        check("R9", "wb1_vld in reset", {63'd0, wb1_vld}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec("table", VEC[i]);

        // R10: wrap of base plus index, fused sum wraps too
        w = '{1'b1, 6'd20, {64{1'b1}}, 64'd1, 2'd0, 1'b1, 6'd21, 6'd20, 64'd0, 64'd2,
              1'b1, 64'd0, 1'b1, 64'd2};
        run_vec("R10", w);
        // R10: index top bit shifted out, only base remains
        w = '{1'b1, 6'd22, 64'd9, 64'h8000_0000_0000_0000, 2'd1, 1'b1, 6'd23, 6'd30, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1,
              1'b1, 64'd9, 1'b1, 64'd0};
        run_vec("R10", w);

        // R12: back-to-back ops, each result one cycle later
        run_vec("R12", VEC[2]);
        run_vec("R12", VEC[0]);

        // R9: synchronous reset mid-stream clears valids at the next edge
        @(negedge clk);
        drive(VEC[0]);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", "wb0_vld after reset", {63'd0, wb0_vld}, 64'd0);
        check("R9", "wb1_vld after reset", {63'd0, wb1_vld}, 64'd0);
        rst_n = 1'b1;
        run_vec("R1", VEC[0]);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule